// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block keeps the status and control word of a double-precision floating-point unit. Each cycle the execute stage can report exception events, either as invalid-operation causes or as overflow, underflow, divide-by-zero and inexact pulses. The matching sticky flags are recorded, and hardware keeps the summary bits consistent with them: the exception summary, the invalid summary and the enabled-exception summary. A set-bit command raises one bit at a time. A masked write reloads whole 4-bit fields while leaving the two protected summary bits alone. A separate port loads the 5-bit result-class code.

The outputs are the register word, a one-hot decode of the 2-bit rounding mode, the enabled-exception summary and a program-interrupt request. The interrupt request is raised only when one of the machine-state floating-point enable inputs is set.

Register layout (LSB = 0):

| Bits | Field |
|------|-------|
| 31 | FX, exception summary (protected) |
| 30 | OX, overflow flag |
| 29 | UX, underflow flag |
| 28 | FEX, enabled-exception summary (protected) |
| 27 | ZX, divide-by-zero flag |
| 26 | XX, inexact flag |
| 25 | VX, invalid summary |
| 24..16 | invalid causes: 24 signaling NaN, 23 inf-inf, 22 inf/inf, 21 0/0, 20 0*inf, 19 invalid compare, 18 software, 17 negative sqrt, 16 integer conversion |
| 15..11 | result class |
| 10..8, 2 | reserved, read 0 |
| 7..3 | enables VE, OE, UE, ZE, XE |
| 1..0 | rounding mode |

Top module: `fpu_status_reg`

## Requirements
- R1: An invalid-cause bit that becomes set, whether through an event pulse (evt_cause bit i sets register bit 16+i) or through set-bit, also sets VX (bit 25) and FX (bit 31).
- R2: Set-bit (set_en, set_idx) sets the addressed bit. FX and the enable check take effect only if that bit was 0 before. Indices 8 to 15 and 2 (reserved and class bits) are ignored.
- R3: FEX (bit 28) is set whenever an exception flag (VX, OX bit 30, UX bit 29, ZX bit 27, XX bit 26) is set while its enable (VE bit 7, OE 6, UE 5, ZE 4, XE 3) is 1.
- R4: Setting an enable bit while its flag is already 1 sets FEX.
- R5: irq_o is 1 exactly when FEX is 1 and at least one msr_fe bit is 1. fex_o mirrors bit 28.
- R6: A masked write replaces field i (bits 4i+3..4i) for every set wr_mask bit i. Bits 31 and 28 keep their previous values, and reserved bits read 0.
- R7: After a masked write, VX equals the OR of bits 24..16, and FEX is set if any flag AND its enable is 1.
- R8: rnd_sel is one-hot on bits 1..0: bit 0 nearest-even (0), bit 1 toward zero (1), bit 2 toward +inf (2), bit 3 toward -inf (3).
- R9: In one cycle, masked write beats set-bit, and set-bit beats event pulses. The losing commands are dropped.
- R10: Event pulses set flags and FX, and never clear anything. Flags and causes clear only through a masked write. FX and FEX clear only on reset.
- R11: cls_we loads cls_val into bits 15..11 unless a masked write is accepted in the same cycle. It does so alongside set-bit or events.
- R12: After reset the register is zero except for bits 1..0, which hold RST_RND.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Masked field write strobe |
| wr_mask | input | 8 | Field select, bit i for bits 4i+3..4i |
| wr_data | input | 32 | Masked write data |
| set_en | input | 1 | Set-bit command strobe |
| set_idx | input | 5 | Bit addressed by set-bit |
| evt_cause | input | 9 | Invalid-cause event pulses |
| evt_arith | input | 4 | Events: 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact |
| cls_we | input | 1 | Result-class load strobe |
| cls_val | input | 5 | New result-class code |
| msr_fe | input | NUM_FE | Machine-state FP exception enables |
| fsr_q | output | 32 | Register value |
| rnd_sel | output | 4 | One-hot rounding mode |
| fex_o | output | 1 | Enabled-exception summary |
| irq_o | output | 1 | Program-interrupt request |

## Verification
The assertions assume that all inputs are known and stable at the rising edge. They also assume that the msr_fe inputs change only between edges, because irq_o follows them combinationally. The bench drives every input 5 ns after the rising edge and holds it until the next edge. It mixes directed sequences for the protected bits, the previously-zero rule and command priority with a long pseudo-random sweep. That sweep keeps masked writes rare, so flags and enables have time to build up before they are cleared.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int FSR_W      = 32;
   localparam int NIB        = FSR_W / 4;
   localparam int B_FX       = 31;
   localparam int B_OX       = 30;
   localparam int B_UX       = 29;
   localparam int B_FEX      = 28;
   localparam int B_ZX       = 27;
   localparam int B_XX       = 26;
   localparam int B_VX       = 25;
   localparam int B_CAUSE_LO = 16;
   localparam int N_CAUSE    = 9;
   localparam int B_CLS_LO   = 11;
   localparam int N_CLS      = 5;
   localparam int B_VE       = 7;
   localparam int B_OE       = 6;
   localparam int B_UE       = 5;
   localparam int B_ZE       = 4;
   localparam int B_XE       = 3;
   localparam int N_PAIR     = 5;

   localparam logic [FSR_W-1:0] RSVD_MASK  = 32'h0000_0704;
   localparam logic [FSR_W-1:0] CLS_MASK   = 32'h0000_F800;
   localparam logic [FSR_W-1:0] CAUSE_MASK = 32'h01FF_0000;

   typedef enum logic [1:0] {
      RN_NEAR = 2'd0,
      RN_ZERO = 2'd1,
      RN_PINF = 2'd2,
      RN_NINF = 2'd3
   } rnd_e;

   function automatic int flag_pos(input int k);
      case (k)
         0:       return B_VX;
         1:       return B_OX;
         2:       return B_UX;
         3:       return B_ZX;
         default: return B_XX;
      endcase
   endfunction

   function automatic int en_pos(input int k);
      case (k)
         0:       return B_VE;
         1:       return B_OE;
         2:       return B_UE;
         3:       return B_ZE;
         default: return B_XE;
      endcase
   endfunction

   function automatic logic pending(input logic [FSR_W-1:0] q);
      logic hit;
      hit = 1'b0;
      for (int k = 0; k < N_PAIR; k++) begin
         hit = hit | (q[flag_pos(k)] & q[en_pos(k)]);
      end
      return hit;
   endfunction
endpackage

// File: rtl/fsr_wr_merge.sv
module fsr_wr_merge
   import fsr_pkg::*;
(
   input  logic [FSR_W-1:0] cur,
   input  logic [NIB-1:0]   mask,
   input  logic [FSR_W-1:0] data,
   output logic [FSR_W-1:0] nxt
);
   logic [FSR_W-1:0] fmask;
   logic [FSR_W-1:0] raw;

   for (genvar g = 0; g < NIB; g++) begin : g_field
      assign fmask[4*g +: 4] = {4{mask[g]}};
   end

   always_comb begin
      raw           = (cur & ~fmask) | (data & fmask);
      raw[B_FX]     = cur[B_FX];
      raw[B_FEX]    = cur[B_FEX];
      raw           = raw & ~RSVD_MASK;
      raw[B_VX]     = |raw[B_CAUSE_LO +: N_CAUSE];
      if (pending(raw)) raw[B_FEX] = 1'b1;
      nxt = raw;
   end
endmodule

// File: rtl/fsr_setbit.sv
module fsr_setbit
   import fsr_pkg::*;
(
   input  logic [FSR_W-1:0] cur,
   input  logic [4:0]       idx,
   output logic [FSR_W-1:0] nxt
);
   logic allowed;

   assign allowed = ~(RSVD_MASK[idx] | CLS_MASK[idx]);

   always_comb begin
      nxt = cur;
      if (allowed && !cur[idx]) begin
         nxt[idx] = 1'b1;
         if (CAUSE_MASK[idx]) begin
            nxt[B_VX] = 1'b1;
            nxt[B_FX] = 1'b1;
            if (cur[B_VE]) nxt[B_FEX] = 1'b1;
         end
         for (int k = 0; k < N_PAIR; k++) begin
            if (int'(idx) == flag_pos(k)) begin
               nxt[B_FX] = 1'b1;
               if (cur[en_pos(k)]) nxt[B_FEX] = 1'b1;
            end
            if (int'(idx) == en_pos(k) && cur[flag_pos(k)]) nxt[B_FEX] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsr_rnd_dec.sv
module fsr_rnd_dec
   import fsr_pkg::*;
(
   input  logic [1:0] rn,
   output logic [3:0] sel
);
   rnd_e mode;
   assign mode = rnd_e'(rn);

   for (genvar i = 0; i < 4; i++) begin : g_sel
      assign sel[i] = (mode == rnd_e'(i));
   end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
   import fsr_pkg::*;
#(
   parameter int         NUM_FE  = 2,
   parameter logic [1:0] RST_RND = 2'b00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NIB-1:0]    wr_mask,
   input  logic [FSR_W-1:0]  wr_data,
   input  logic              set_en,
   input  logic [4:0]        set_idx,
   input  logic [N_CAUSE-1:0] evt_cause,
   input  logic [3:0]        evt_arith,
   input  logic              cls_we,
   input  logic [N_CLS-1:0]  cls_val,
   input  logic [NUM_FE-1:0] msr_fe,
   output logic [FSR_W-1:0]  fsr_q,
   output logic [3:0]        rnd_sel,
   output logic              fex_o,
   output logic              irq_o
);
   if (NUM_FE < 1 || NUM_FE > 8) begin : g_bad_fe
      $error("fpu_status_reg: NUM_FE out of range");
   end

   localparam logic [FSR_W-1:0] RST_VAL = {{(FSR_W-2){1'b0}}, RST_RND};

   logic [FSR_W-1:0] st_q, st_d;
   logic [FSR_W-1:0] wr_nxt, sb_nxt, ev_nxt;
   logic             fe_any;

   fsr_wr_merge u_merge (.cur(st_q), .mask(wr_mask), .data(wr_data), .nxt(wr_nxt));
   fsr_setbit   u_setb  (.cur(st_q), .idx(set_idx), .nxt(sb_nxt));
   fsr_rnd_dec  u_rdec  (.rn(st_q[1:0]), .sel(rnd_sel));

   always_comb begin
      ev_nxt = st_q;
      ev_nxt[B_CAUSE_LO +: N_CAUSE] = st_q[B_CAUSE_LO +: N_CAUSE] | evt_cause;
      if (|evt_cause) ev_nxt[B_VX] = 1'b1;
      ev_nxt[B_OX] = st_q[B_OX] | evt_arith[3];
      ev_nxt[B_UX] = st_q[B_UX] | evt_arith[2];
      ev_nxt[B_ZX] = st_q[B_ZX] | evt_arith[1];
      ev_nxt[B_XX] = st_q[B_XX] | evt_arith[0];
      if (|evt_cause || |evt_arith) ev_nxt[B_FX] = 1'b1;
      if (pending(ev_nxt)) ev_nxt[B_FEX] = 1'b1;
   end

   always_comb begin
      if (wr_en)       st_d = wr_nxt;
      else if (set_en) st_d = sb_nxt;
      else             st_d = ev_nxt;
      if (cls_we && !wr_en) st_d[B_CLS_LO +: N_CLS] = cls_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RST_VAL;
      else        st_q <= st_d;
   end

   if (NUM_FE == 1) begin : g_fe_one
      assign fe_any = msr_fe[0];
   end else begin : g_fe_many
      assign fe_any = |msr_fe;
   end

   assign fsr_q = st_q;
   assign fex_o = st_q[B_FEX];
   assign irq_o = st_q[B_FEX] & fe_any;

   AST_VX_COVERS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|fsr_q[B_CAUSE_LO +: N_CAUSE]) |-> fsr_q[B_VX]) else $error("AST_VX_COVERS_CAUSE"); // R1
   AST_FEX_COVERS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      pending(fsr_q) |-> fex_o) else $error("AST_FEX_COVERS_PEND"); // R3
   AST_FX_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> $stable(fsr_q[B_FX])) else $error("AST_FX_PROTECTED"); // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fsr_q & RSVD_MASK) == '0) else $error("AST_RSVD_ZERO"); // R6
   AST_OX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && fsr_q[B_OX]) |=> fsr_q[B_OX]) else $error("AST_OX_STICKY"); // R10
   AST_FEX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fex_o |=> fex_o) else $error("AST_FEX_STICKY"); // R10
   AST_RND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(rnd_sel)) else $error("AST_RND_ONEHOT"); // R8
   AST_IRQ_NEEDS_FE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|msr_fe && fex_o)) else $error("AST_IRQ_NEEDS_FE"); // R5
endmodule

// File: tb/fpu_status_reg_bench.sv
module fpu_status_reg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_mask = '0;
   logic [31:0] wr_data = '0;
   logic        set_en = 1'b0;
   logic [4:0]  set_idx = '0;
   logic [8:0]  evt_cause = '0;
   logic [3:0]  evt_arith = '0;
   logic        cls_we = 1'b0;
   logic [4:0]  cls_val = '0;
   logic [1:0]  msr_fe = '0;
   logic [31:0] fsr_q;
   logic [3:0]  rnd_sel;
   logic        fex_o, irq_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_q = '0;
   logic [31:0] rs = 32'h1234_5678;

   always #10 clk = ~clk;

   fpu_status_reg u_fpu_status_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
      .set_en(set_en), .set_idx(set_idx), .evt_cause(evt_cause), .evt_arith(evt_arith),
      .cls_we(cls_we), .cls_val(cls_val), .msr_fe(msr_fe),
      .fsr_q(fsr_q), .rnd_sel(rnd_sel), .fex_o(fex_o), .irq_o(irq_o));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic pend(input logic [31:0] n);
      return (n[25] & n[7]) | (n[30] & n[6]) | (n[29] & n[5]) | (n[27] & n[4]) | (n[26] & n[3]);
   endfunction

   function automatic logic [31:0] mdl(input logic [31:0] c);
      logic [31:0] n;
      n = c;
      if (wr_en) begin
         for (int f = 0; f < 8; f++) if (wr_mask[f]) n[4*f +: 4] = wr_data[4*f +: 4];
         n[31] = c[31]; n[28] = c[28];
         n[10:8] = 3'b000; n[2] = 1'b0;
         n[25] = |n[24:16];
         if (pend(n)) n[28] = 1'b1;
      end else if (set_en) begin
         if (!((set_idx >= 5'd8 && set_idx <= 5'd15) || set_idx == 5'd2) && !c[set_idx]) begin
            n[set_idx] = 1'b1;
            if (set_idx >= 5'd16 && set_idx <= 5'd24) begin
               n[25] = 1'b1; n[31] = 1'b1; if (c[7]) n[28] = 1'b1;
            end
            case (set_idx)
               5'd25: begin n[31] = 1'b1; if (c[7]) n[28] = 1'b1; end
               5'd30: begin n[31] = 1'b1; if (c[6]) n[28] = 1'b1; end
               5'd29: begin n[31] = 1'b1; if (c[5]) n[28] = 1'b1; end
               5'd27: begin n[31] = 1'b1; if (c[4]) n[28] = 1'b1; end
               5'd26: begin n[31] = 1'b1; if (c[3]) n[28] = 1'b1; end
               5'd7:  if (c[25]) n[28] = 1'b1;
               5'd6:  if (c[30]) n[28] = 1'b1;
               5'd5:  if (c[29]) n[28] = 1'b1;
               5'd4:  if (c[27]) n[28] = 1'b1;
               5'd3:  if (c[26]) n[28] = 1'b1;
               default: ;
            endcase
         end
      end else if (|evt_cause || |evt_arith) begin
         n[24:16] = n[24:16] | evt_cause;
         if (|evt_cause) n[25] = 1'b1;
         n[30] = n[30] | evt_arith[3];
         n[29] = n[29] | evt_arith[2];
         n[27] = n[27] | evt_arith[1];
         n[26] = n[26] | evt_arith[0];
         n[31] = 1'b1;
         if (pend(n)) n[28] = 1'b1;
      end
      if (cls_we && !wr_en) n[15:11] = cls_val;
      return n;
   endfunction

   task automatic idle();
      wr_en = 1'b0; set_en = 1'b0; evt_cause = '0; evt_arith = '0; cls_we = 1'b0;
   endtask

   task automatic tick(input string tag);
      logic [31:0] nx;
      nx = mdl(exp_q);
      @(posedge clk);
      #5;
      exp_q = nx;
      chk({tag, " reg"}, fsr_q, exp_q);
      chk({tag, " rnd R8"}, {28'd0, rnd_sel}, 32'd1 << exp_q[1:0]);
      chk({tag, " irq R5"}, {31'd0, irq_o}, {31'd0, exp_q[28] & (|msr_fe)});
      idle();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      #5;
      rst_n = 1'b1;
      exp_q = '0;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(posedge clk); @(posedge clk); #5;
      rst_n = 1'b1;
      // R12 reset state
      chk("R12 reset value", fsr_q, 32'h0);
      chk("R12 reset rnd R8", {28'd0, rnd_sel}, 32'h1);

      // R1 cause event
      evt_cause = 9'h100;
      tick("R1 snan event");
      chk("R1 literal", fsr_q, 32'h8300_0000);
      // R4 enable with flag already set
      set_en = 1'b1; set_idx = 5'd7;
      tick("R4 enable after flag");
      chk("R4 literal", fsr_q, 32'h9300_0080);
      chk("R5 irq masked by msr_fe", {31'd0, irq_o}, 32'd0);
      msr_fe = 2'b10; #1;
      chk("R5 irq with msr_fe", {31'd0, irq_o}, 32'd1);
      msr_fe = 2'b00;
      // R10 sticky over idle cycles
      tick("R10 idle");
      tick("R10 idle");
      chk("R10 sticky literal", fsr_q, 32'h9300_0080);

      // R6 R7 full write from clean state
      do_reset();
      wr_en = 1'b1; wr_mask = 8'hFF; wr_data = 32'hFFFF_FFFF;
      tick("R6 full write");
      chk("R6 R7 literal", fsr_q, 32'h7FFF_F8FB);
      chk("R8 toward -inf", {28'd0, rnd_sel}, 32'h8);
      wr_en = 1'b1; wr_mask = 8'hFF; wr_data = 32'h0;
      tick("R7 clear write");
      chk("R6 protected FEX literal", fsr_q, 32'h1000_0000);
      msr_fe = 2'b01; #1;
      chk("R5 irq after write", {31'd0, irq_o}, 32'd1);
      msr_fe = 2'b00;

      // R9 priority
      do_reset();
      wr_en = 1'b1; wr_mask = 8'h01; wr_data = 32'h3;
      set_en = 1'b1; set_idx = 5'd27; evt_arith = 4'b1000;
      tick("R9 write wins");
      chk("R9 literal", fsr_q, 32'h3);
      set_en = 1'b1; set_idx = 5'd30; evt_arith = 4'b0001;
      tick("R9 set-bit wins");
      chk("R9 set literal", fsr_q, 32'hC000_0003);

      // R2 ignored indices and class R11
      set_en = 1'b1; set_idx = 5'd12;
      tick("R2 class idx ignored");
      set_en = 1'b1; set_idx = 5'd9;
      tick("R2 reserved idx ignored");
      chk("R2 ignore literal", fsr_q, 32'hC000_0003);
      cls_we = 1'b1; cls_val = 5'h15; set_en = 1'b1; set_idx = 5'd5;
      tick("R11 class with set-bit");
      chk("R11 literal", fsr_q, 32'hC000_A823);
      cls_we = 1'b1; cls_val = 5'h1F; wr_en = 1'b1; wr_mask = 8'h00;
      tick("R11 blocked by write");
      chk("R11 blocked literal", fsr_q & 32'h0000_F800, 32'h0000_A800);

      // R2 previously-one rule, R4 enable
      do_reset();
      wr_en = 1'b1; wr_mask = 8'h40; wr_data = 32'h0800_0000;
      tick("R2 preload ZX");
      set_en = 1'b1; set_idx = 5'd27;
      tick("R2 already set");
      chk("R2 FX untouched", {31'd0, fsr_q[31]}, 32'd0);
      set_en = 1'b1; set_idx = 5'd4;
      tick("R4 ZE after ZX");
      chk("R4 FEX", {31'd0, fex_o}, 32'd1);
      evt_arith = 4'b0100;
      tick("R3 R10 UX event");

      // R9 R3 R1 R10 pseudo-random sweep
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
         wr_en     = (rs[2:0] == 3'd0);
         wr_mask   = rs[15:8];
         wr_data   = {rs[7:0], rs[31:8]};
         set_en    = (rs[4:3] == 2'd0);
         set_idx   = rs[20:16];
         evt_cause = (rs[31:29] == 3'd0) ? rs[28:20] : 9'd0;
         evt_arith = rs[27:24] & {4{rs[6]}};
         cls_we    = rs[5] & rs[21];
         cls_val   = rs[12:8];
         msr_fe    = rs[23:22];
         tick("R9 sweep");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule